// File: doc/BRIEF.md
# ADC Completion Interrupt Vector Unit

This block gathers the interrupt sources of a multi-slot analog-to-digital converter and presents them to a processor as one prioritised vector code. Each result slot has a pending flag. The flag is raised when the conversion engine writes a result into that slot, and it is lowered when software reads that slot's result. Two further flags report faults. The data-overrun flag is detected inside the block: a result was written to a slot whose previous result was still unread. The timing-overrun flag is raised by a pulse from the sequencer when a sample request arrives while a conversion is still in progress.

The vector output is an even number. It names the highest-priority source that is both pending and enabled, and it is zero when no such source exists. A read of the vector clears the two fault flags on the next clock. The slot flags stay set, because software still has to fetch each result. The interrupt request line is high whenever a vector is on offer. Bus decoding is reduced to direct strobes, and result storage sits outside the block.

Top module: `adc_irq_vector`

## Requirements
- R1: After a clock edge with rst_n low, all slot flags, both fault flags, the vector and the interrupt request are 0.
- R2: A clock edge with wr_valid high sets the slot flag selected by wr_slot (bit index equals slot number in slot_flags).
- R3: A clock edge with rd_strobe[i] high clears slot flag i, unless slot i is written on the same edge, in which case the flag ends set.
- R4: A write to a slot whose flag is already set sets ovf_flag on that edge, unless rd_strobe for that slot is high on the same edge; a write to a clear slot leaves ovf_flag unchanged.
- R5: A clock edge with tov_pulse high sets tov_flag.
- R6: A clock edge with vec_rd high clears ovf_flag and tov_flag unless their own set event occurs on the same edge (set wins); vec_rd leaves every slot flag unchanged.
- R7: The vector is combinational: 2 if ovf_flag and ov_en are high; otherwise 4 if tov_flag and tov_en are high; otherwise 6+2*i for the lowest-numbered slot i with both its flag and slot_en[i] high; otherwise 0.
- R8: A source whose enable is low does not contribute to the vector, yet its flag still sets and reads out on the flag outputs.
- R9: irq is high exactly when the vector is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | A conversion result is written this cycle |
| wr_slot | input | SLOT_W (4) | Slot receiving the result |
| rd_strobe | input | NUM_SLOTS (16) | One bit per slot: that slot's result is read this cycle |
| tov_pulse | input | 1 | Sample request arrived during a conversion |
| vec_rd | input | 1 | The vector is read this cycle |
| slot_en | input | NUM_SLOTS (16) | Per-slot interrupt enable |
| ov_en | input | 1 | Enable for the data-overrun source |
| tov_en | input | 1 | Enable for the timing-overrun source |
| slot_flags | output | NUM_SLOTS (16) | Pending flag per slot |
| ovf_flag | output | 1 | Data-overrun flag |
| tov_flag | output | 1 | Timing-overrun flag |
| vector | output | VEC_W (6) | Prioritised even vector code, 0 to 36 |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with the default sixteen slots. With that setting the vector spans its full range, from code 6 at slot 0 to code 36 at slot 15, and the slot index uses its whole 4-bit field with no unused codes. Random traffic writes slots often and reads them rarely, so the overrun path fires again and again and its interaction with same-cycle reads can be checked. The enable masks are also varied, and most of them leave several sources pending together. This exercises the priority order between the fault sources and the slots, and among the slots themselves.

// File: rtl/adc_irq_pkg.sv
// Package adc_irq_pkg
// Shared vector codes for the ADC interrupt vector unit.
// Assumes vector codes are even and that slots occupy codes above the faults.
package adc_irq_pkg;
    localparam int VEC_NONE      = 0;
    localparam int VEC_OVF       = 2;
    localparam int VEC_TOV       = 4;
    localparam int VEC_SLOT_BASE = 6;

    // Vector code assigned to result slot idx.
    function automatic int slot_code(input int idx);
        return VEC_SLOT_BASE + 2 * idx;
    endfunction
endpackage

// File: rtl/adc_slot_flags.sv
// Module adc_slot_flags
// Holds one pending flag per result slot. A write sets a flag and a read
// clears it; when both hit the same slot on one edge the set wins.
// Assumes NUM_SLOTS is a power of two so every wr_slot value names a slot.
module adc_slot_flags #(
    parameter int NUM_SLOTS = 16,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_valid,
    input  logic [SLOT_W-1:0]    wr_slot,
    input  logic [NUM_SLOTS-1:0] rd_strobe,
    output logic [NUM_SLOTS-1:0] flags_q
);
    logic [NUM_SLOTS-1:0] set_vec;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        // Decode the write strobe for this slot.
        assign set_vec[i] = wr_valid && (wr_slot == SLOT_W'(i));

        // Pending flag register: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)              flags_q[i] <= 1'b0;
            else if (set_vec[i])     flags_q[i] <= 1'b1;
            else if (rd_strobe[i])   flags_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_fault_flags.sv
// Module adc_fault_flags
// Holds the data-overrun and timing-overrun flags. Both clear when the
// vector is read; a set event on the same edge overrides the clear.
// Assumes the overrun event is already qualified by the caller.
module adc_fault_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic ovr_evt,
    input  logic tov_pulse,
    input  logic vec_rd,
    output logic ovf_q,
    output logic tov_q
);
    // Data-overrun flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)        ovf_q <= 1'b0;
        else if (ovr_evt)  ovf_q <= 1'b1;
        else if (vec_rd)   ovf_q <= 1'b0;
    end

    // Timing-overrun flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)          tov_q <= 1'b0;
        else if (tov_pulse)  tov_q <= 1'b1;
        else if (vec_rd)     tov_q <= 1'b0;
    end
endmodule

// File: rtl/adc_vec_encoder.sv
// Module adc_vec_encoder
// Pure combinational priority encoder: data overrun, then timing overrun,
// then the lowest-numbered enabled pending slot. Produces 0 when idle.
// Assumes VEC_W holds the largest slot code.
module adc_vec_encoder
    import adc_irq_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int VEC_W     = 6
) (
    input  logic [NUM_SLOTS-1:0] slot_pend,
    input  logic                 ovf_act,
    input  logic                 tov_act,
    output logic [VEC_W-1:0]     vec
);
    // Scan slots high to low so the lowest index is written last and wins.
    always_comb begin
        vec = VEC_W'(VEC_NONE);
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (slot_pend[i]) vec = VEC_W'(slot_code(i));
        end
        if (tov_act) vec = VEC_W'(VEC_TOV);
        if (ovf_act) vec = VEC_W'(VEC_OVF);
    end
endmodule

// File: rtl/adc_irq_vector.sv
// Module adc_irq_vector
// Top of the ADC interrupt vector unit. It detects data overrun, holds the
// slot and fault flags, and encodes the enabled, pending sources into one
// even vector with an interrupt request.
// Assumes single-cycle strobes from a simplified bus decode.
module adc_irq_vector #(
    parameter int NUM_SLOTS = 16,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int VEC_W    = $clog2(adc_irq_pkg::VEC_SLOT_BASE + 2 * NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_valid,
    input  logic [SLOT_W-1:0]    wr_slot,
    input  logic [NUM_SLOTS-1:0] rd_strobe,
    input  logic                 tov_pulse,
    input  logic                 vec_rd,
    input  logic [NUM_SLOTS-1:0] slot_en,
    input  logic                 ov_en,
    input  logic                 tov_en,
    output logic [NUM_SLOTS-1:0] slot_flags,
    output logic                 ovf_flag,
    output logic                 tov_flag,
    output logic [VEC_W-1:0]     vector,
    output logic                 irq
);
    logic ovr_evt;

    // Overrun: the target slot still holds an unread result and is not read now.
    assign ovr_evt = wr_valid && slot_flags[wr_slot] && !rd_strobe[wr_slot];

    adc_slot_flags #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W)
    ) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_slot   (wr_slot),
        .rd_strobe (rd_strobe),
        .flags_q   (slot_flags)
    );

    adc_fault_flags u_faults (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovr_evt   (ovr_evt),
        .tov_pulse (tov_pulse),
        .vec_rd    (vec_rd),
        .ovf_q     (ovf_flag),
        .tov_q     (tov_flag)
    );

    adc_vec_encoder #(
        .NUM_SLOTS (NUM_SLOTS),
        .VEC_W     (VEC_W)
    ) u_enc (
        .slot_pend (slot_flags & slot_en),
        .ovf_act   (ovf_flag && ov_en),
        .tov_act   (tov_flag && tov_en),
        .vec       (vector)
    );

    // Request whenever any vector code is presented.
    assign irq = (vector != '0);
endmodule

// File: rtl/adc_irq_vector_checker.sv
// Module adc_irq_vector_checker
// Temporal properties of the interrupt vector unit, bound to the top.
// Assumes the default encoding of vector codes from adc_irq_pkg.
module adc_irq_vector_checker #(
    parameter int NUM_SLOTS = 16,
    parameter int SLOT_W    = 4,
    parameter int VEC_W     = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_valid,
    input logic [SLOT_W-1:0]    wr_slot,
    input logic [NUM_SLOTS-1:0] rd_strobe,
    input logic                 tov_pulse,
    input logic                 vec_rd,
    input logic [NUM_SLOTS-1:0] slot_en,
    input logic                 ov_en,
    input logic                 tov_en,
    input logic [NUM_SLOTS-1:0] slot_flags,
    input logic                 ovf_flag,
    input logic                 tov_flag,
    input logic [VEC_W-1:0]     vector,
    input logic                 irq
);
    logic [SLOT_W-1:0] hit_idx;
    // Slot index named by a slot vector code.
    assign hit_idx = SLOT_W'((vector - VEC_W'(6)) >> 1);

    // R2: a write sets the addressed flag
    a_r2_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> slot_flags[$past(wr_slot)]);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_rd
        // R3: a read with no same-slot write clears the flag
        a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_strobe[i] && !(wr_valid && wr_slot == SLOT_W'(i))) |=> !slot_flags[i]);
    end

    // R4: writing an unread slot raises the overrun flag
    a_r4_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && slot_flags[wr_slot] && !rd_strobe[wr_slot]) |=> ovf_flag);

    // R5: timing pulse raises its flag
    a_r5_tov_sets: assert property (@(posedge clk) disable iff (!rst_n)
        tov_pulse |=> tov_flag);

    // R6: vector read clears the timing flag absent a new pulse
    a_r6_tov_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && !tov_pulse) |=> !tov_flag);

    // R6: vector read with no slot read keeps every slot flag
    a_r6_slots_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && rd_strobe == '0) |=> ((slot_flags & $past(slot_flags)) == $past(slot_flags)));

    // R7: enabled data overrun takes the top code
    a_r7_ovf_first: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && ov_en) |-> vector == VEC_W'(2));

    // R7: enabled timing overrun is next
    a_r7_tov_second: assert property (@(posedge clk) disable iff (!rst_n)
        (tov_flag && tov_en && !(ovf_flag && ov_en)) |-> vector == VEC_W'(4));

    // R8: a slot code only names an enabled, pending slot
    a_r8_slot_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (vector >= VEC_W'(6)) |-> (slot_en[hit_idx] && slot_flags[hit_idx]));

    // R9: an enabled fault source always drives the request
    a_r9_irq_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        ((ovf_flag && ov_en) || (tov_flag && tov_en)) |-> irq);

    // R7: codes are even
    a_r7_even: assert property (@(posedge clk) disable iff (!rst_n)
        !vector[0]);
endmodule

bind adc_irq_vector adc_irq_vector_checker #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_W    (SLOT_W),
    .VEC_W     (VEC_W)
) u_chk (.*);

// File: tb/adc_irq_vector_bench.sv
`timescale 1ns/1ps
module adc_irq_vector_bench;
    localparam int N  = 16;
    localparam int SW = 4;
    localparam int VW = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_valid;
    logic [SW-1:0] wr_slot;
    logic [N-1:0]  rd_strobe;
    logic          tov_pulse;
    logic          vec_rd;
    logic [N-1:0]  slot_en;
    logic          ov_en;
    logic          tov_en;
    logic [N-1:0]  slot_flags;
    logic          ovf_flag;
    logic          tov_flag;
    logic [VW-1:0] vector;
    logic          irq;

    int checks = 0;
    int fails  = 0;

    logic [N-1:0] m_slots;
    logic         m_ovf;
    logic         m_tov;

    always #2.5 clk = ~clk;

    adc_irq_vector #(.NUM_SLOTS(N)) u_adc_irq_vector (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_slot(wr_slot),
        .rd_strobe(rd_strobe), .tov_pulse(tov_pulse), .vec_rd(vec_rd),
        .slot_en(slot_en), .ov_en(ov_en), .tov_en(tov_en),
        .slot_flags(slot_flags), .ovf_flag(ovf_flag), .tov_flag(tov_flag),
        .vector(vector), .irq(irq)
    );

    // Expected vector from the priority rule.
    function automatic int exp_vec(input logic [N-1:0] s, input logic o, input logic t,
                                   input logic [N-1:0] en, input logic oe, input logic te);
        if (o && oe) return 2;
        if (t && te) return 4;
        for (int i = 0; i < N; i++) if (s[i] && en[i]) return 6 + 2 * i;
        return 0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare all outputs against the model state with the current enables.
    task automatic check_model();
        int ev;
        ev = exp_vec(m_slots, m_ovf, m_tov, slot_en, ov_en, tov_en);
        check("R2/R3 slot flags", int'(slot_flags), int'(m_slots));
        check("R4 ovf_flag", int'(ovf_flag), int'(m_ovf));
        check("R5 tov_flag", int'(tov_flag), int'(m_tov));
        check("R7 vector", int'(vector), ev);
        check("R9 irq", int'(irq), int'(ev != 0));
    endtask

    // Apply one cycle of events, check before the edge, advance the model.
    task automatic step(input logic w, input int s, input logic [N-1:0] rd,
                        input logic tp, input logic vr);
        logic [N-1:0] ns;
        logic         no, nt;
        @(negedge clk);
        wr_valid = w; wr_slot = SW'(s); rd_strobe = rd; tov_pulse = tp; vec_rd = vr;
        #1;
        check_model();
        ns = m_slots; no = m_ovf; nt = m_tov;
        for (int i = 0; i < N; i++) if (rd[i]) ns[i] = 1'b0;
        if (w) ns[s] = 1'b1;
        if (vr) begin no = 1'b0; nt = 1'b0; end
        if (w && m_slots[s] && !rd[s]) no = 1'b1;
        if (tp) nt = 1'b1;
        @(posedge clk);
        m_slots = ns; m_ovf = no; m_tov = nt;
        #1;
        wr_valid = 0; rd_strobe = '0; tov_pulse = 0; vec_rd = 0;
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0; wr_valid = 0; wr_slot = '0; rd_strobe = '0; tov_pulse = 0;
        vec_rd = 0; slot_en = '1; ov_en = 1; tov_en = 1;
        m_slots = '0; m_ovf = 0; m_tov = 0;
        repeat (3) @(posedge clk);
        settle();
        check("R1 reset flags", int'(slot_flags), 0);
        check("R1 reset faults", int'({ovf_flag, tov_flag}), 0);
        check("R1 reset vector", int'(vector), 0);
        check("R1 reset irq", int'(irq), 0);
        rst_n = 1;

        step(1, 3, '0, 0, 0); settle();
        check("R2 slot3 set", int'(slot_flags), 16'h0008);
        check("R7 slot3 code", int'(vector), 12);
        check("R9 irq high", int'(irq), 1);

        step(1, 3, '0, 0, 0); settle();
        check("R4 overrun vector", int'(vector), 2);

        step(0, 0, '0, 0, 1); settle();
        check("R6 ovf cleared", int'(ovf_flag), 0);
        check("R6 slot kept", int'(slot_flags), 16'h0008);

        step(1, 5, 16'h0020, 0, 0); settle();
        check("R3 set wins", int'(slot_flags), 16'h0028);
        check("R7 lowest slot", int'(vector), 12);

        step(0, 0, 16'h0008, 0, 0); settle();
        check("R3 read clears", int'(slot_flags), 16'h0020);
        check("R7 slot5 code", int'(vector), 16);

        step(0, 0, '0, 1, 0); settle();
        check("R5 tov vector", int'(vector), 4);

        step(0, 0, '0, 1, 1); settle();
        check("R6 tov set wins", int'(tov_flag), 1);

        step(0, 0, '0, 0, 1); settle();
        check("R6 tov cleared", int'(vector), 16);

        slot_en = '0;
        step(0, 0, '0, 0, 0); settle();
        check("R8 disabled vector", int'(vector), 0);
        check("R8 flag still set", int'(slot_flags), 16'h0020);

        step(1, 5, 16'h0020, 0, 0); settle();
        check("R4 no overrun on read", int'(ovf_flag), 0);

        ov_en = 0;
        step(1, 5, '0, 0, 0); settle();
        check("R8 ovf flagged", int'(ovf_flag), 1);
        check("R8 ovf masked", int'(vector), 0);

        slot_en = 16'h8000; ov_en = 1;
        step(0, 0, '0, 0, 1);
        step(1, 15, '0, 0, 0); settle();
        check("R7 top slot code", int'(vector), 36);

        for (int n = 0; n < 3000; n++) begin
            logic [N-1:0] rd;
            rd = '0;
            if ($urandom_range(3) == 0) rd[$urandom_range(N-1)] = 1'b1;
            if ($urandom_range(15) == 0) rd = N'($urandom);
            if (n % 64 == 0) begin
                slot_en = ($urandom_range(3) == 0) ? N'($urandom) : '1;
                ov_en  = ($urandom_range(3) != 0);
                tov_en = ($urandom_range(3) != 0);
            end
            step($urandom_range(1) == 0, $urandom_range(N-1), rd,
                 $urandom_range(9) == 0, $urandom_range(7) == 0);
        end
        settle();
        check_model();
        finish_run();
    end
endmodule